// File: doc/BRIEF.md
# Slave Address Matcher

This block decides whether a bus slave is being addressed. The bit-level receiver hands it the first byte after a start condition as one parallel word with a one-cycle valid strobe. The upper seven bits of that byte are the address and bit 0 is the read/write bit. The block compares the address with a programmed own address, bit by bit, under a programmed compare mask. When enabled, it also recognises the general call address. One clock after the strobe it reports whether the slave was selected, whether the selection came from a general call, and the transfer mode to use next.

Control logic picks one of two acknowledge styles. With hardware acknowledge on, a selected address is acknowledged automatically. If automatic direction is also on, the block moves into transmit or receive mode from the read/write bit. With hardware acknowledge off, the block raises an acknowledge request and holds it until control logic returns a decision. A slave-inhibit input makes the block deaf to every address.

Top module: `slave_addr_matcher`

## Requirements
- R1: The received byte carries the address in bits 7:1 and the read/write bit in bit 0. Each address bit is compared with `own_addr` only where the matching `addr_mask` bit is 1. A mask bit of 0 makes that address bit a don't-care.
- R2: With `gc_enable` high, the byte 8'h00 selects the slave and sets `gc_match` to 1. The byte 8'h01 is not a general call. With `gc_enable` low, 8'h00 selects the slave only through the masked own-address compare.
- R3: A selection made by the own-address compare, where the byte is not a general call, sets `gc_match` to 0. When the byte is a general call and also matches the own address, `gc_match` is 1.
- R4: While `slave_inhibit` is high, a strobe never sets `addressed`, `ack_request` or `ack_valid`, whatever the byte.
- R5: `addressed`, `gc_match` and `tx_mode` update on the clock edge that samples `byte_valid` and then hold until the next strobe. All outputs are 0 after reset.
- R6: With `hw_ack_en` high, a selecting strobe gives a one-cycle `ack_valid` pulse with `ack_value` = 1 in the same cycle that `addressed` rises. It does not raise `ack_request`.
- R7: With `hw_ack_en` low, a selecting strobe raises `ack_request` and holds it until `ack_dec_valid`. On that edge the request clears and a one-cycle `ack_valid` pulse follows, with `ack_value` equal to `ack_dec`.
- R8: `ack_dec_valid` has no effect while no request is pending. A new strobe replaces a pending request with its own result.
- R9: `tx_mode` becomes the read/write bit (1 = read = transmit, 0 = write = receive) of a selecting byte only when `auto_dir_en` and `hw_ack_en` are both high. In every other case it is 0.
- R10: A strobe that selects nothing leaves `addressed`, `gc_match`, `tx_mode`, `ack_request` and `ack_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | One-cycle strobe marking `rx_byte` as the address byte |
| rx_byte | input | 8 | Address byte: bits 7:1 address, bit 0 read/write |
| own_addr | input | 7 | Programmed slave address |
| addr_mask | input | 7 | Per-bit compare enable, 1 = compare |
| gc_enable | input | 1 | Accept the general call address |
| slave_inhibit | input | 1 | Ignore all addresses |
| hw_ack_en | input | 1 | Acknowledge a selecting address automatically |
| auto_dir_en | input | 1 | With `hw_ack_en`, set transmit/receive mode from the read/write bit |
| ack_dec_valid | input | 1 | Control logic supplies an acknowledge decision |
| ack_dec | input | 1 | Decision: 1 = acknowledge, 0 = not acknowledge |
| addressed | output | 1 | Last address byte selected this slave |
| gc_match | output | 1 | Selection came from a general call |
| tx_mode | output | 1 | 1 = transmit next, 0 = receive |
| ack_request | output | 1 | Waiting for an acknowledge decision |
| ack_valid | output | 1 | One-cycle pulse: `ack_value` is to be driven on the bus |
| ack_value | output | 1 | Acknowledge value to drive |

## Verification
A wrong compare or a wrong general call decode shows on `addressed` and `gc_match` on the edge that samples the strobe, so the next sample after every strobe exposes it. A stuck request or a lost acknowledge pulse shows on `ack_request` and `ack_valid` within one cycle of the decision. A corrupted hold register shows as output changes during the idle cycles between strobes. Random bytes are biased toward near-matches under random masks and toward 8'h00 and 8'h01, so single-bit compare faults and general call decode faults are hit often.

// File: rtl/slvmatch_pkg.sv
package slvmatch_pkg;
  typedef enum logic [0:0] {
    ACK_IDLE = 1'b0,
    ACK_WAIT = 1'b1
  } ack_state_t;

  typedef struct packed {
    logic hit;
    logic gc;
    logic tx;
  } match_result_t;
endpackage

// File: rtl/slvmatch_compare.sv
module slvmatch_compare #(
  parameter int AW = 7,
  localparam int BW = AW + 1
) (
  input  logic [BW-1:0] rx_byte,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] addr_mask,
  input  logic          gc_enable,
  input  logic          slave_inhibit,
  output logic          own_hit,
  output logic          gc_hit,
  output logic          accept
);
  logic [AW-1:0] bit_ok;

  // One comparator cell per address bit; bit 0 of the byte is the direction.
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = ~addr_mask[i] | (rx_byte[i+1] ~^ own_addr[i]);
  end

  function automatic logic is_gc_pattern(input logic [BW-1:0] b);
    return (b == '0);
  endfunction

  assign own_hit = &bit_ok;
  assign gc_hit  = gc_enable & is_gc_pattern(rx_byte);
  assign accept  = ~slave_inhibit & (own_hit | gc_hit);
endmodule

// File: rtl/slvmatch_result.sv
module slvmatch_result
  import slvmatch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  match_result_t next_res,
  output match_result_t res_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (strobe) res_q <= next_res;
  end
endmodule

// File: rtl/slvmatch_ack.sv
module slvmatch_ack
  import slvmatch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic accept,
  input  logic hw_ack_en,
  input  logic ack_dec_valid,
  input  logic ack_dec,
  output logic ack_request,
  output logic ack_valid,
  output logic ack_value,
  output logic dec_taken
);
  ack_state_t state_q, state_d;
  logic       vld_d, val_d;
  logic       vld_q, val_q;

  assign dec_taken = (state_q == ACK_WAIT) & ack_dec_valid & ~strobe;

  always_comb begin
    state_d = state_q;
    vld_d   = 1'b0;
    val_d   = val_q;
    if (strobe) begin
      state_d = (accept & ~hw_ack_en) ? ACK_WAIT : ACK_IDLE;
      if (accept & hw_ack_en) begin
        vld_d = 1'b1;
        val_d = 1'b1;
      end
    end else if (dec_taken) begin
      state_d = ACK_IDLE;
      vld_d   = 1'b1;
      val_d   = ack_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      vld_q   <= 1'b0;
      val_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      val_q   <= val_d;
    end
  end

  assign ack_request = (state_q == ACK_WAIT);
  assign ack_valid   = vld_q;
  assign ack_value   = val_q;
endmodule

// File: rtl/slave_addr_matcher.sv
module slave_addr_matcher
  import slvmatch_pkg::*;
#(
  parameter int AW = 7,
  localparam int BW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [BW-1:0] rx_byte,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] addr_mask,
  input  logic          gc_enable,
  input  logic          slave_inhibit,
  input  logic          hw_ack_en,
  input  logic          auto_dir_en,
  input  logic          ack_dec_valid,
  input  logic          ack_dec,
  output logic          addressed,
  output logic          gc_match,
  output logic          tx_mode,
  output logic          ack_request,
  output logic          ack_valid,
  output logic          ack_value
);
  logic          own_hit, gc_hit, accept, dec_taken;
  match_result_t next_res, res_q;

  slvmatch_compare #(.AW(AW)) u_cmp (
    .rx_byte(rx_byte), .own_addr(own_addr), .addr_mask(addr_mask),
    .gc_enable(gc_enable), .slave_inhibit(slave_inhibit),
    .own_hit(own_hit), .gc_hit(gc_hit), .accept(accept)
  );

  always_comb begin
    next_res.hit = accept;
    next_res.gc  = accept & gc_hit;
    next_res.tx  = accept & hw_ack_en & auto_dir_en & rx_byte[0];
  end

  slvmatch_result u_res (
    .clk(clk), .rst_n(rst_n), .strobe(byte_valid),
    .next_res(next_res), .res_q(res_q)
  );

  slvmatch_ack u_ack (
    .clk(clk), .rst_n(rst_n), .strobe(byte_valid), .accept(accept),
    .hw_ack_en(hw_ack_en), .ack_dec_valid(ack_dec_valid), .ack_dec(ack_dec),
    .ack_request(ack_request), .ack_valid(ack_valid), .ack_value(ack_value),
    .dec_taken(dec_taken)
  );

  assign addressed = res_q.hit;
  assign gc_match  = res_q.gc;
  assign tx_mode   = res_q.tx;
endmodule

// File: rtl/slave_addr_matcher_chk.sv
module slave_addr_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic slave_inhibit,
  input logic hw_ack_en,
  input logic ack_dec_valid,
  input logic ack_dec,
  input logic accept_i,
  input logic dec_taken_i,
  input logic addressed,
  input logic gc_match,
  input logic tx_mode,
  input logic ack_request,
  input logic ack_valid,
  input logic ack_value
);
  assert_inhibit_deaf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && slave_inhibit |=> !addressed && !ack_request && !ack_valid);

  assert_gc_implies_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gc_match |-> addressed);

  assert_hold_between_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> $stable(addressed) && $stable(gc_match) && $stable(tx_mode));

  assert_hw_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && accept_i && hw_ack_en |=> ack_valid && ack_value && !ack_request);

  assert_request_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_request && !byte_valid && !ack_dec_valid |=> ack_request);

  assert_decision_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_taken_i |=> !ack_request && ack_valid && (ack_value == $past(ack_dec)));

  assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid && !ack_request |=> !ack_valid);

  assert_tx_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode |-> addressed);
endmodule

bind slave_addr_matcher slave_addr_matcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
  .slave_inhibit(slave_inhibit), .hw_ack_en(hw_ack_en),
  .ack_dec_valid(ack_dec_valid), .ack_dec(ack_dec),
  .accept_i(accept), .dec_taken_i(dec_taken),
  .addressed(addressed), .gc_match(gc_match), .tx_mode(tx_mode),
  .ack_request(ack_request), .ack_valid(ack_valid), .ack_value(ack_value)
);

// File: tb/tb_slave_addr_matcher.sv
`timescale 1ns/1ps
module tb_slave_addr_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [6:0] own_addr = '0;
  logic [6:0] addr_mask = '0;
  logic       gc_enable = 1'b0, slave_inhibit = 1'b0;
  logic       hw_ack_en = 1'b0, auto_dir_en = 1'b0;
  logic       ack_dec_valid = 1'b0, ack_dec = 1'b0;
  logic       addressed, gc_match, tx_mode, ack_request, ack_valid, ack_value;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slave_addr_matcher dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .own_addr(own_addr), .addr_mask(addr_mask), .gc_enable(gc_enable),
    .slave_inhibit(slave_inhibit), .hw_ack_en(hw_ack_en),
    .auto_dir_en(auto_dir_en), .ack_dec_valid(ack_dec_valid), .ack_dec(ack_dec),
    .addressed(addressed), .gc_match(gc_match), .tx_mode(tx_mode),
    .ack_request(ack_request), .ack_valid(ack_valid), .ack_value(ack_value)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference: address compare written as a bit loop over the byte.
  function automatic bit ref_own(input logic [7:0] b, input logic [6:0] a, input logic [6:0] m);
    for (int i = 1; i < 8; i++)
      if (m[i-1] && (b[i] != a[i-1])) return 0;
    return 1;
  endfunction

  function automatic bit ref_gc(input logic [7:0] b);
    return gc_enable && (b == 8'h00);
  endfunction

  function automatic bit ref_sel(input logic [7:0] b);
    if (slave_inhibit) return 0;
    return ref_own(b, own_addr, addr_mask) || ref_gc(b);
  endfunction

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    rx_byte = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic decide(input logic d);
    @(negedge clk);
    ack_dec_valid = 1'b1;
    ack_dec = d;
    @(negedge clk);
    ack_dec_valid = 1'b0;
  endtask

  // Sends one byte and checks every output against the reference.
  task automatic run_one(input logic [7:0] b, input logic d, input int wait_cyc);
    bit sel, gc, tx;
    sel = ref_sel(b);
    gc  = sel && ref_gc(b);
    tx  = sel && hw_ack_en && auto_dir_en && b[0];
    strobe(b);
    chk("R1 addressed", {7'd0, addressed}, {7'd0, sel});
    chk("R2/R3 gc_match", {7'd0, gc_match}, {7'd0, gc});
    chk("R9 tx_mode", {7'd0, tx_mode}, {7'd0, tx});
    if (sel && hw_ack_en) begin
      chk("R6 ack pulse", {6'd0, ack_valid, ack_value}, 8'h03);
      chk("R6 no request", {7'd0, ack_request}, 8'h00);
    end else if (sel) begin
      chk("R7 request up", {6'd0, ack_request, ack_valid}, 8'h02);
      for (int k = 0; k < wait_cyc; k++) begin
        @(negedge clk);
        chk("R7 request held", {7'd0, ack_request}, 8'h01);
      end
      decide(d);
      chk("R7 decision", {5'd0, ack_request, ack_valid, ack_value}, {6'd0, 1'b1, d});
    end else begin
      chk("R10 nothing", {6'd0, ack_request, ack_valid}, 8'h00);
    end
    @(negedge clk);
    chk("R5 hold", {5'd0, addressed, gc_match, tx_mode}, {5'd0, sel, gc, tx});
    chk("R6/R7 pulse ends", {7'd0, ack_valid}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R5 reset outputs",
        {2'd0, addressed, gc_match, tx_mode, ack_request, ack_valid, ack_value}, 8'h00);
    rst_n = 1'b1;

    // Directed: exact compare, hardware ack, auto direction read.
    own_addr = 7'h2A; addr_mask = 7'h7F; hw_ack_en = 1; auto_dir_en = 1;
    run_one({7'h2A, 1'b1}, 1'b0, 0);
    run_one({7'h2A, 1'b0}, 1'b0, 0);
    run_one({7'h2B, 1'b1}, 1'b0, 0);
    // R1: mask zero bit 0 -> 0x2B accepted
    addr_mask = 7'h7E;
    run_one({7'h2B, 1'b1}, 1'b0, 0);
    // R9: auto without hw ack gives receive mode
    hw_ack_en = 0;
    run_one({7'h2A, 1'b1}, 1'b1, 2);
    // R2: general call on / off, and 0x01 is not general call
    addr_mask = 7'h7F; gc_enable = 1; hw_ack_en = 1;
    run_one(8'h00, 1'b0, 0);
    run_one(8'h01, 1'b0, 0);
    gc_enable = 0;
    run_one(8'h00, 1'b0, 0);
    // R3: own address zero plus general call -> gc flag
    own_addr = 7'h00; gc_enable = 1;
    run_one(8'h00, 1'b0, 0);
    // R4: inhibit with an all-don't-care mask
    addr_mask = 7'h00; slave_inhibit = 1;
    run_one(8'h00, 1'b0, 0);
    run_one(8'hA5, 1'b0, 0);
    slave_inhibit = 0;
    // R8: decision with nothing pending
    decide(1'b1);
    chk("R8 stray decision", {6'd0, ack_request, ack_valid}, 8'h00);
    // R8: new non-selecting strobe replaces a pending request
    own_addr = 7'h11; addr_mask = 7'h7F; hw_ack_en = 0;
    strobe({7'h11, 1'b0});
    chk("R7 pending", {7'd0, ack_request}, 8'h01);
    strobe({7'h12, 1'b0});
    chk("R8 replaced", {6'd0, ack_request, addressed}, 8'h00);
    decide(1'b1);
    chk("R8 late decision ignored", {7'd0, ack_valid}, 8'h00);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      int sel_kind;
      own_addr      = 7'($urandom);
      addr_mask     = ($urandom % 2) ? 7'h7F : 7'($urandom);
      gc_enable     = 1'($urandom);
      slave_inhibit = (($urandom % 8) == 0);
      hw_ack_en     = 1'($urandom);
      auto_dir_en   = 1'($urandom);
      sel_kind      = $urandom % 4;
      case (sel_kind)
        0: b = {own_addr ^ (7'($urandom) & ~addr_mask), 1'($urandom)};
        1: b = 8'h00;
        2: b = 8'h01;
        default: b = 8'($urandom);
      endcase
      run_one(b, 1'($urandom), $urandom % 3);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule